// File: doc/BRIEF.md
# Audio Sample Fetch Channel

This block is a single background audio playback voice. A phase accumulator, advanced by a programmable rate on every enabled clock, decides when the next sample is due. When a sample is due, the channel asks a memory arbiter for the bytes of that sample through a request/grant port. The arbiter may grant on any later cycle, for example during otherwise idle bus cycles. The fetched bytes become the held sample. The held sample, multiplied by an 8-bit volume, drives a signed 16-bit audio output.

Software programs the channel through a byte-wide register write port. It sets a 24-bit start address, a 16-bit end marker, a 24-bit repeat address, a 24-bit rate, a volume, and a control byte that selects enable, repeat, sine mode and sample format. At the end marker the channel either jumps to the repeat address or halts and raises a sticky stop flag. In sine mode the address sequence is unchanged, but the sample values come from an internal 32-point table and no memory traffic is generated. The current address is visible on a port at all times, without latching.

Top module: `audio_fetch_channel`

## Requirements
- R1: After synchronous reset, every register is zero, `fetch_req` is low, `stopped` is low, `cur_addr` is 0 and `sample_out` is 0.
- R2: Register selects with defaults 0 = control, 1..3 = start address (low byte first), 4..5 = end marker, 6..8 = repeat address, 9..11 = rate, and 12 = volume. Control bit 7 is enable, bit 6 is repeat, bit 5 is sine mode, and bits 1:0 select the format. Writes to selects 13..15 change nothing.
- R3: While enabled, the 24-bit rate is added to the 24-bit accumulator on each clock. Every carry out of bit 23 is one sample tick. When not in sine mode and no request is outstanding, a tick raises `fetch_req` on the next cycle.
- R4: `fetch_req` stays high until `fetch_gnt` is seen. `fetch_data` is taken in the grant cycle. A tick that arrives while a request is outstanding is discarded.
- R5: Format 0 fetches one byte and gives sample = byte<<8. Format 1 fetches the low byte at the current address, then the high byte at the current address + 1. Format 2 takes bits 3:0 of the byte and format 3 takes bits 7:4, each giving sample = nibble<<12. The address advances by 2 for format 1 and by 1 for the others, after the sample's last byte is granted.
- R6: When a sample completes, bits 15:0 of its first-byte address are compared with the end marker. On a match with repeat set, the address reloads from the 24-bit repeat register instead of advancing.
- R7: On an end match with repeat clear, the channel clears its enable and sets `stopped`. `stopped` holds until the next write to the control register.
- R8: In sine mode, each tick loads sample = S(address bits 5:1) and advances the address by 2, with the same end handling, and `fetch_req` never rises. S(i) for i = 0..8 is 0, 6393, 12539, 18204, 23170, 27245, 30273, 32137, 32767. For i = 9..16, S(i) = S(16-i). For i = 17..31, S(i) = -S(i-16).
- R9: `sample_out` = floor(sample × volume / 256), a signed multiply with volume unsigned. It follows a volume write on the next cycle, and volume 0 gives 0.
- R10: A control write with enable clear freezes the address and the accumulator and drops any outstanding request. A control write that sets enable while the channel is disabled loads the start address and clears the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 8 | Register write byte |
| fetch_req | output | 1 | Byte fetch request to the arbiter |
| fetch_addr | output | 24 | Address of the requested byte |
| fetch_gnt | input | 1 | Arbiter grant; data valid in this cycle |
| fetch_data | input | 8 | Fetched byte |
| cur_addr | output | 24 | Live current sample address |
| stopped | output | 1 | Sticky end-of-sample flag |
| sample_out | output | 16 | Signed volume-scaled sample |

## Verification
Playback is run in four patterns. The first is 8-bit samples with an immediate grant, a start address whose low half wraps past 0xFFFF, and no repeat; it separates a 16-bit end compare from a full-width one and confirms the stop. The second is 16-bit samples with repeat, random grant delays and a rate fast enough that ticks collide with pending requests; it exposes byte ordering, discarded ticks and repeat reload. The third plays low and high nibbles, and the fourth runs sine mode. Sine mode shows that the table is indexed by the address while the fetch port stays silent. Volume changes during playback and the enable-off/enable-on sequences check scaling, freezing and start reload.

// File: rtl/afc_pkg.sv
// Package for the audio fetch channel: sample formats, register select
// defaults and the built-in sine table (quarter wave plus symmetry).
package afc_pkg;

    typedef enum logic [1:0] {
        FMT_BYTE   = 2'd0,
        FMT_WORD   = 2'd1,
        FMT_NIB_LO = 2'd2,
        FMT_NIB_HI = 2'd3
    } afc_fmt_e;

    localparam int SMP_W        = 16;
    localparam int VOL_W        = 8;
    localparam int SEL_W        = 4;
    localparam int CTRL_EN_BIT  = 7;
    localparam int CTRL_RPT_BIT = 6;
    localparam int CTRL_SIN_BIT = 5;

    // First quadrant of the sine table, k = 0..8.
    function automatic logic signed [SMP_W-1:0] sine_quarter(input logic [3:0] k);
        case (k)
            4'd0:    return 16'sd0;
            4'd1:    return 16'sd6393;
            4'd2:    return 16'sd12539;
            4'd3:    return 16'sd18204;
            4'd4:    return 16'sd23170;
            4'd5:    return 16'sd27245;
            4'd6:    return 16'sd30273;
            4'd7:    return 16'sd32137;
            default: return 16'sd32767;
        endcase
    endfunction

    // Full 32-point table built from the quadrant by mirror and negation.
    function automatic logic signed [SMP_W-1:0] sine_value(input logic [4:0] idx);
        logic [3:0] half;
        logic [3:0] k;
        half = idx[3:0];
        k    = (half <= 4'd8) ? half : 4'(5'd16 - {1'b0, half});
        return idx[4] ? -sine_quarter(k) : sine_quarter(k);
    endfunction

endpackage

// File: rtl/afc_regs.sv
// Register file of the channel. Holds the static playback settings written
// through the byte port, and decodes control writes for the sequencer.
// Assumes every address, end and rate width is a multiple of 8.
module afc_regs
    import afc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CMP_W  = 16,
    parameter int RATE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [SEL_W-1:0]  sel,
    input  logic [7:0]        wdata,
    output logic              ctrl_wr,
    output logic              ctrl_en,
    output logic              rpt_en,
    output logic              sine_en,
    output afc_fmt_e          fmt,
    output logic [ADDR_W-1:0] start_addr,
    output logic [CMP_W-1:0]  end_mark,
    output logic [ADDR_W-1:0] rpt_addr,
    output logic [RATE_W-1:0] rate,
    output logic [VOL_W-1:0]  volume
);
    localparam int ADDR_B    = ADDR_W / 8;
    localparam int CMP_B     = CMP_W / 8;
    localparam int RATE_B    = RATE_W / 8;
    localparam int OFF_START = 1;
    localparam int OFF_END   = OFF_START + ADDR_B;
    localparam int OFF_RPT   = OFF_END + CMP_B;
    localparam int OFF_RATE  = OFF_RPT + ADDR_B;
    localparam int OFF_VOL   = OFF_RATE + RATE_B;

    // Control write decode, used by the sequencer in the same cycle.
    assign ctrl_wr = wr && (sel == '0);
    assign ctrl_en = wdata[CTRL_EN_BIT];

    // Capture settings byte by byte at their selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_en     <= 1'b0;
            sine_en    <= 1'b0;
            fmt        <= FMT_BYTE;
            start_addr <= '0;
            end_mark   <= '0;
            rpt_addr   <= '0;
            rate       <= '0;
            volume     <= '0;
        end else if (wr) begin
            if (ctrl_wr) begin
                rpt_en  <= wdata[CTRL_RPT_BIT];
                sine_en <= wdata[CTRL_SIN_BIT];
                fmt     <= afc_fmt_e'(wdata[1:0]);
            end
            for (int i = 0; i < ADDR_B; i++) begin
                if (int'(sel) == OFF_START + i) start_addr[8*i +: 8] <= wdata;
                if (int'(sel) == OFF_RPT + i)   rpt_addr[8*i +: 8]   <= wdata;
            end
            for (int i = 0; i < CMP_B; i++) begin
                if (int'(sel) == OFF_END + i) end_mark[8*i +: 8] <= wdata;
            end
            for (int i = 0; i < RATE_B; i++) begin
                if (int'(sel) == OFF_RATE + i) rate[8*i +: 8] <= wdata;
            end
            if (int'(sel) == OFF_VOL) volume <= wdata[VOL_W-1:0];
        end
    end
endmodule

// File: rtl/afc_pacer.sv
// Phase accumulator that paces sample ticks. It adds the rate on every
// enabled clock, and the carry out of the top bit is the tick. Assumes
// restart is asserted only together with a start of playback.
module afc_pacer #(
    parameter int RATE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [RATE_W-1:0] acc_q;
    logic [RATE_W:0]   sum;

    assign sum  = {1'b0, acc_q} + {1'b0, rate};
    assign tick = en && sum[RATE_W];

    // Accumulate while enabled; clear on a fresh start.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (restart) acc_q <= '0;
        else if (en)      acc_q <= sum[RATE_W-1:0];
    end
endmodule

// File: rtl/afc_seq.sv
// Playback sequencer: enable and stop state, current address, end/repeat
// handling and the byte fetch handshake. It emits load strobes for the
// sample path. Assumes fetch_data is valid in the grant cycle.
module afc_seq
    import afc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CMP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ctrl_en,
    input  logic              rpt_en,
    input  logic              sine_en,
    input  afc_fmt_e          fmt,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CMP_W-1:0]  end_mark,
    input  logic [ADDR_W-1:0] rpt_addr,
    input  logic              tick,
    input  logic              fetch_gnt,
    output logic              en,
    output logic              restart,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              stopped,
    output logic              lo_load,
    output logic              fin_load,
    output logic              sine_load
);
    logic              en_q, stop_q, req_q, phase_q;
    logic [ADDR_W-1:0] cur_q;
    logic              active, take, advance, at_end;
    logic [1:0]        step;

    assign active    = en_q && !ctrl_wr;
    assign sine_load = active && sine_en && tick;
    assign take      = active && !sine_en && req_q && fetch_gnt;
    assign lo_load   = take && (fmt == FMT_WORD) && !phase_q;
    assign fin_load  = take && !lo_load;
    assign advance   = sine_load || fin_load;
    assign at_end    = (cur_q[CMP_W-1:0] == end_mark);
    assign step      = (sine_en || fmt == FMT_WORD) ? 2'd2 : 2'd1;
    assign restart   = ctrl_wr && ctrl_en && !en_q;

    assign en         = en_q;
    assign fetch_req  = req_q;
    assign fetch_addr = cur_q + ADDR_W'(phase_q);
    assign cur_addr   = cur_q;
    assign stopped    = stop_q;

    // Control writes take priority; otherwise run fetch and address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            stop_q  <= 1'b0;
            req_q   <= 1'b0;
            phase_q <= 1'b0;
            cur_q   <= '0;
        end else if (ctrl_wr) begin
            en_q    <= ctrl_en;
            stop_q  <= 1'b0;
            req_q   <= 1'b0;
            phase_q <= 1'b0;
            if (restart) cur_q <= start_addr;
        end else begin
            if (advance) begin
                if (!at_end)     cur_q <= cur_q + ADDR_W'(step);
                else if (rpt_en) cur_q <= rpt_addr;
                else begin
                    en_q   <= 1'b0;
                    stop_q <= 1'b1;
                end
            end
            if (active && !sine_en) begin
                if (req_q) begin
                    if (lo_load)  phase_q <= 1'b1;
                    if (fin_load) begin
                        req_q   <= 1'b0;
                        phase_q <= 1'b0;
                    end
                end else if (tick) begin
                    req_q <= 1'b1;
                end
            end
        end
    end

    // R4: an ungranted request survives unless a control write drops it.
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !fetch_gnt && !ctrl_wr) |=> req_q);

    // R8: sine playback never drives the fetch port.
    assert_sine_no_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sine_en |-> !req_q);

    // R7: a raised stop flag always comes with a halted channel.
    assert_stop_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |-> !en_q);

    // R10: the address does not move while the channel is disabled.
    assert_idle_addr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !ctrl_wr) |=> $stable(cur_q));
endmodule

// File: rtl/afc_sample.sv
// Sample path: assembles fetched bytes or sine entries into the held
// sample and scales it by the volume with a signed multiply.
// Assumes the load strobes are mutually exclusive.
module afc_sample
    import afc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lo_load,
    input  logic                    fin_load,
    input  logic                    sine_load,
    input  afc_fmt_e                fmt,
    input  logic [7:0]              fetch_data,
    input  logic [4:0]              sine_idx,
    input  logic [VOL_W-1:0]        volume,
    output logic signed [SMP_W-1:0] sample_out
);
    logic        [7:0]         lo_q;
    logic signed [SMP_W-1:0]   held_q;
    logic signed [SMP_W-1:0]   fetched;
    logic signed [SMP_W+VOL_W:0] prod;

    // Build the signed sample from the last fetched byte(s).
    always_comb begin
        case (fmt)
            FMT_WORD:   fetched = {fetch_data, lo_q};
            FMT_NIB_LO: fetched = {fetch_data[3:0], 12'h000};
            FMT_NIB_HI: fetched = {fetch_data[7:4], 12'h000};
            default:    fetched = {fetch_data, 8'h00};
        endcase
    end

    // Hold the low byte and the finished sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            held_q <= '0;
        end else begin
            if (lo_load)   lo_q   <= fetch_data;
            if (fin_load)  held_q <= fetched;
            if (sine_load) held_q <= sine_value(sine_idx);
        end
    end

    assign prod       = held_q * $signed({1'b0, volume});
    assign sample_out = prod[SMP_W+VOL_W-1:VOL_W];

    // R9: a muted channel outputs silence.
    assert_mute_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (volume == '0) |-> (sample_out == '0));
endmodule

// File: rtl/audio_fetch_channel.sv
// Top of one audio sample fetch channel. It ties together the register
// file, the rate pacer, the playback sequencer and the sample path.
// Assumes an external arbiter answers fetch_req with a one-cycle grant.
module audio_fetch_channel
    import afc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CMP_W  = 16,
    parameter int RATE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_gnt,
    input  logic [7:0]        fetch_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              stopped,
    output logic [15:0]       sample_out
);
    logic              ctrl_wr, ctrl_en, rpt_en, sine_en;
    afc_fmt_e          fmt;
    logic [ADDR_W-1:0] start_addr, rpt_addr;
    logic [CMP_W-1:0]  end_mark;
    logic [RATE_W-1:0] rate;
    logic [VOL_W-1:0]  volume;
    logic              en, restart, tick;
    logic              lo_load, fin_load, sine_load;
    logic signed [SMP_W-1:0] smp;

    afc_regs #(.ADDR_W(ADDR_W), .CMP_W(CMP_W), .RATE_W(RATE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en), .rpt_en(rpt_en), .sine_en(sine_en),
        .fmt(fmt), .start_addr(start_addr), .end_mark(end_mark),
        .rpt_addr(rpt_addr), .rate(rate), .volume(volume)
    );

    afc_pacer #(.RATE_W(RATE_W)) u_pacer (
        .clk(clk), .rst_n(rst_n), .en(en), .restart(restart),
        .rate(rate), .tick(tick)
    );

    afc_seq #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en),
        .rpt_en(rpt_en), .sine_en(sine_en), .fmt(fmt),
        .start_addr(start_addr), .end_mark(end_mark), .rpt_addr(rpt_addr),
        .tick(tick), .fetch_gnt(fetch_gnt), .en(en), .restart(restart),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .cur_addr(cur_addr),
        .stopped(stopped), .lo_load(lo_load), .fin_load(fin_load),
        .sine_load(sine_load)
    );

    afc_sample u_sample (
        .clk(clk), .rst_n(rst_n), .lo_load(lo_load), .fin_load(fin_load),
        .sine_load(sine_load), .fmt(fmt), .fetch_data(fetch_data),
        .sine_idx(cur_addr[5:1]), .volume(volume), .sample_out(smp)
    );

    assign sample_out = smp;
endmodule

// File: tb/audio_fetch_channel_tb.sv
// Bench for audio_fetch_channel: a behavioural reference model compared
// against the outputs on every clock, plus directed end-of-scenario checks.
module audio_fetch_channel_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        fetch_gnt = 1'b0;
    logic [7:0]  fetch_data = '0;
    logic        fetch_req, stopped;
    logic [23:0] fetch_addr, cur_addr;
    logic [15:0] sample_out;

    audio_fetch_channel u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_gnt(fetch_gnt), .fetch_data(fetch_data), .cur_addr(cur_addr),
        .stopped(stopped), .sample_out(sample_out)
    );

    int    checks = 0;
    int    failures = 0;
    string phase_tag = "R1 reset";
    bit    grant_random = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int    req_rises = 0;
    int    req_cycles = 0;
    logic  prev_req = 1'b0;
    logic  live = 1'b0;

    // Reference model state
    logic              m_en, m_rpt, m_sine, m_req, m_ph, m_stop;
    logic [1:0]        m_fmt;
    logic [23:0]       m_start, m_rptaddr, m_rate, m_acc, m_cur;
    logic [15:0]       m_end;
    logic [7:0]        m_vol, m_lo;
    logic signed [15:0] m_held;

    function automatic int ref_sine(int i);
        int q[9] = '{0, 6393, 12539, 18204, 23170, 27245, 30273, 32137, 32767};
        if (i <= 8)  return q[i];
        if (i < 16)  return q[16 - i];
        return -ref_sine(i - 16);
    endfunction

    function automatic logic [7:0] mem_byte(logic [23:0] a);
        int v;
        v = int'(a) * 37 + int'(a >> 8) * 11 + 5;
        return v[7:0];
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL [%s] %s actual=%0h expected=%0h", phase_tag, what, act, exp);
        end
    endtask

    // Reference model: advance one clock from the requirements.
    always @(posedge clk) begin : ref_model
        logic [24:0] s;
        logic        tk, adv, en_n, stop_n, req_n, ph_n;
        logic [23:0] cur_n, acc_n;
        logic [7:0]  lo_n;
        logic signed [15:0] held_n;
        live <= rst_n;
        if (!rst_n) begin
            m_en = 0; m_rpt = 0; m_sine = 0; m_req = 0; m_ph = 0; m_stop = 0;
            m_fmt = 0; m_start = 0; m_rptaddr = 0; m_rate = 0; m_acc = 0;
            m_cur = 0; m_end = 0; m_vol = 0; m_lo = 0; m_held = 0;
        end else begin
            s = {1'b0, m_acc} + {1'b0, m_rate};
            tk = m_en && s[24];
            en_n = m_en; stop_n = m_stop; req_n = m_req; ph_n = m_ph;
            cur_n = m_cur; lo_n = m_lo; held_n = m_held; adv = 0;
            acc_n = m_en ? s[23:0] : m_acc;
            if (reg_wr && reg_sel == 4'd0) begin
                if (reg_wdata[7] && !m_en) begin
                    cur_n = m_start;
                    acc_n = 0;
                end
                en_n = reg_wdata[7]; stop_n = 0; req_n = 0; ph_n = 0;
            end else if (m_en) begin
                if (m_sine) begin
                    if (tk) begin
                        held_n = 16'(ref_sine(int'(m_cur[5:1])));
                        adv = 1;
                    end
                end else if (m_req) begin
                    if (fetch_gnt) begin
                        if (m_fmt == 2'd1 && !m_ph) begin
                            lo_n = fetch_data;
                            ph_n = 1;
                        end else begin
                            case (m_fmt)
                                2'd0: held_n = {fetch_data, 8'h00};
                                2'd1: held_n = {fetch_data, m_lo};
                                2'd2: held_n = {fetch_data[3:0], 12'h000};
                                default: held_n = {fetch_data[7:4], 12'h000};
                            endcase
                            req_n = 0; ph_n = 0; adv = 1;
                        end
                    end
                end else if (tk) begin
                    req_n = 1;
                end
                if (adv) begin
                    if (m_cur[15:0] == m_end) begin
                        if (m_rpt) cur_n = m_rptaddr;
                        else begin en_n = 0; stop_n = 1; end
                    end else begin
                        cur_n = m_cur + ((m_sine || m_fmt == 2'd1) ? 24'd2 : 24'd1);
                    end
                end
            end
            if (reg_wr) begin
                case (reg_sel)
                    4'd0:  begin m_rpt = reg_wdata[6]; m_sine = reg_wdata[5]; m_fmt = reg_wdata[1:0]; end
                    4'd1:  m_start[7:0]    = reg_wdata;
                    4'd2:  m_start[15:8]   = reg_wdata;
                    4'd3:  m_start[23:16]  = reg_wdata;
                    4'd4:  m_end[7:0]      = reg_wdata;
                    4'd5:  m_end[15:8]     = reg_wdata;
                    4'd6:  m_rptaddr[7:0]  = reg_wdata;
                    4'd7:  m_rptaddr[15:8] = reg_wdata;
                    4'd8:  m_rptaddr[23:16]= reg_wdata;
                    4'd9:  m_rate[7:0]     = reg_wdata;
                    4'd10: m_rate[15:8]    = reg_wdata;
                    4'd11: m_rate[23:16]   = reg_wdata;
                    4'd12: m_vol           = reg_wdata;
                    default: ;
                endcase
            end
            m_en = en_n; m_stop = stop_n; m_req = req_n; m_ph = ph_n;
            m_cur = cur_n; m_acc = acc_n; m_lo = lo_n; m_held = held_n;
        end
    end

    // Per-cycle comparison away from the edge, then drive the arbiter model.
    always @(negedge clk) begin : compare_and_grant
        int p;
        if (live) begin
            p = (int'(m_held) * int'(m_vol)) >>> 8;
            check("fetch_req R3,R4", 32'(fetch_req), 32'(m_req));
            check("fetch_addr R5", 32'(fetch_addr), 32'(m_cur + 24'(m_ph)));
            check("cur_addr R6,R10", 32'(cur_addr), 32'(m_cur));
            check("stopped R7", 32'(stopped), 32'(m_stop));
            check("sample_out R9", 32'(sample_out), 32'(p[15:0]));
            if (fetch_req && !prev_req) req_rises++;
            if (fetch_req) req_cycles++;
        end
        prev_req = fetch_req;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        fetch_gnt  = fetch_req && (!grant_random || (lfsr[0] & lfsr[3]));
        fetch_data = mem_byte(fetch_addr);
    end

    task automatic wr_reg(input logic [3:0] sel, input logic [7:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [23:0] frozen;
        run(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 fetch_req", 32'(fetch_req), 0);
        check("R1 stopped", 32'(stopped), 0);
        check("R1 cur_addr", 32'(cur_addr), 0);
        check("R1 sample_out", 32'(sample_out), 0);

        // 8-bit, no repeat, low half wraps through 0xFFFF (R5 R6 R7 R3)
        phase_tag = "R5 byte / R6 low-16 end";
        wr_reg(1, 8'hFC); wr_reg(2, 8'hFF); wr_reg(3, 8'h12);
        wr_reg(4, 8'h02); wr_reg(5, 8'h00);
        wr_reg(9, 8'h00); wr_reg(10, 8'h00); wr_reg(11, 8'h40);
        wr_reg(12, 8'h80);
        req_rises = 0;
        wr_reg(0, 8'h80);
        run(60);
        check("R7 stopped after end", 32'(stopped), 1);
        check("R6 address held at end", 32'(cur_addr), 32'h130002);
        check("R3 one request per sample", 32'(req_rises), 7);
        run(10);
        check("R7 stop is sticky", 32'(stopped), 1);
        wr_reg(0, 8'h00);
        check("R7 control write clears stop", 32'(stopped), 0);

        // 16-bit with repeat, random grants, colliding ticks (R4 R5 R6 R9)
        phase_tag = "R4 R5 word repeat";
        grant_random = 1'b1;
        wr_reg(1, 8'h00); wr_reg(2, 8'h40); wr_reg(3, 8'h00);
        wr_reg(4, 8'h06); wr_reg(5, 8'h40);
        wr_reg(6, 8'h02); wr_reg(7, 8'h40); wr_reg(8, 8'h00);
        wr_reg(11, 8'hF0); wr_reg(12, 8'hC0);
        wr_reg(0, 8'hC1);
        run(150);
        check("R6 address stays in repeat window", 32'(cur_addr >= 24'h004000 && cur_addr <= 24'h004006), 1);
        phase_tag = "R9 live volume";
        wr_reg(12, 8'hFF);
        run(50);
        wr_reg(12, 8'h00);
        run(2);
        check("R9 volume 0 mutes", 32'(sample_out), 0);
        phase_tag = "R10 disable freezes";
        wr_reg(0, 8'h41);
        frozen = cur_addr;
        run(20);
        check("R10 address frozen", 32'(cur_addr), 32'(frozen));
        check("R10 request dropped", 32'(fetch_req), 0);

        // Nibble formats and restart reload (R5 R10)
        phase_tag = "R5 low nibble";
        wr_reg(1, 8'h00); wr_reg(2, 8'h01); wr_reg(3, 8'h00);
        wr_reg(4, 8'h08); wr_reg(5, 8'h01);
        wr_reg(6, 8'h04); wr_reg(7, 8'h01); wr_reg(8, 8'h00);
        wr_reg(9, 8'h55); wr_reg(10, 8'h55); wr_reg(11, 8'h55);
        wr_reg(12, 8'hFF);
        wr_reg(0, 8'hC2);
        run(120);
        wr_reg(0, 8'h00);
        phase_tag = "R5 high nibble";
        wr_reg(0, 8'hC3);
        check("R10 enable reloads start", 32'(cur_addr), 32'h000100);
        run(120);
        wr_reg(0, 8'h00);

        // Sine mode (R8) with an unmapped write in the middle (R2)
        phase_tag = "R8 sine";
        grant_random = 1'b0;
        wr_reg(1, 8'h00); wr_reg(2, 8'h00); wr_reg(3, 8'h00);
        wr_reg(4, 8'h3E); wr_reg(5, 8'h00);
        wr_reg(6, 8'h00); wr_reg(7, 8'h00); wr_reg(8, 8'h00);
        wr_reg(9, 8'h00); wr_reg(10, 8'h00); wr_reg(11, 8'h20);
        req_cycles = 0;
        wr_reg(0, 8'hE0);
        run(150);
        phase_tag = "R2 unmapped select";
        wr_reg(4'd15, 8'hFF);
        wr_reg(4'd13, 8'h00);
        run(150);
        check("R8 no fetch in sine mode", 32'(req_cycles), 0);
        check("R2 sine still running", 32'(stopped), 0);
        wr_reg(0, 8'h00);
        run(4);
        finish_run();
    end
endmodule